// File: doc/BRIEF.md
# I2C Target Engine with Byte-Boundary Clock Stretching

This block is the target (slave) side of a two-wire serial bus. It watches SCL and SDA through a synchronizer in the system clock domain and finds START and STOP conditions. It compares the 7-bit address sent by the controller with an own-address register written by the host, and then moves data bytes through one shared data register. Bytes travel most significant bit first in both directions. Both lines are driven as open-drain outputs: an `*_oe` output high means the block pulls that line low.

At every byte boundary the engine raises `irq` and pulls SCL low, which stalls the controller until the host has serviced the byte. The hold has no release command of its own. In transmit mode a write to the data register releases it, and in receive mode a read of the data register releases it. This lets an interrupt routine stay in step with the bus without a separate handshake. The host port is a plain register port with single-cycle read and write strobes and no back-pressure. `reg_rdata` is combinational from `reg_sel`.

Register selects are: 0 for the data register, 1 for the own address (bits 6:0), and 2 for status. The status bits are bit 0 for the interrupt flag, bit 1 for address matched, bit 2 for transmit mode and bit 3 for the last acknowledge bit sampled from the controller (1 means NACK).

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset both lines are released, `irq` and `addr_hit` are 0, and the data register and own-address register both read 0.
- R2: When the 7 address bits after a START equal the own address, the engine pulls SDA low during the acknowledge clock and sets `irq` and `addr_hit`.
- R3: When the address does not match, the engine does not acknowledge, does not set `irq`, and leaves SDA released for the rest of that transfer, including any further bytes, until the next START or STOP.
- R4: The eighth address bit selects the direction. A 1 (controller reads) puts the engine in transmit mode and a 0 (controller writes) puts it in receive mode. Status bit 2 shows which mode is active.
- R5: In receive mode each byte is assembled most significant bit first and can be read from the data register. Every received byte is acknowledged.
- R6: In transmit mode each byte is taken from the data register and sent most significant bit first.
- R7: At the end of every byte (address or data) the engine holds SCL low and keeps `irq` set until the host services the data register.
- R8: The hold is released by a data-register write in transmit mode and by a data-register read in receive mode. A data-register read in transmit mode, a data-register write in receive mode, and any status access each leave the hold in place.
- R9: A NACK from the controller in transmit mode ends transmission. The engine then keeps SDA released, so further clocks read all ones until the next START.
- R10: A STOP or a repeated START returns the engine to the address phase and clears the hold, `irq` and `addr_hit`.
- R11: The own-address register changes only on a host write to it. Bus traffic never modifies it.
- R12: The engine changes its SDA drive only while SCL is low, apart from the reaction to a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen on the pad |
| sda_i | input | 1 | SDA line level as seen on the pad |
| scl_oe | output | 1 | High pulls SCL low (stretch) |
| sda_oe | output | 1 | High pulls SDA low |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_sel | input | 2 | Register select: 0 data, 1 own address, 2 status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Byte-boundary interrupt flag |
| addr_hit | output | 1 | Own address matched in the current transfer |

## Verification
The hardest situation to reach from the ports is a stall held open on purpose: SCL pinned low with `irq` set while the host makes the accesses that must not end it. These are the status read, a data read while transmitting, and a data write while receiving. The controller must also honour the stretch and must not race ahead. The bench models the bus as a wired-AND of a controller model and the block's open-drain outputs. The controller only moves on once it sees SCL actually high. A concurrent host thread waits on `irq`, lingers, probes the hold with non-releasing accesses, and only then makes the releasing access. A NACK on the last read byte followed by an extra clocked byte exercises the end-of-transmission path. A sweep over every non-matching address exercises the ignore path.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  // Bus phase of the target engine
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // ignoring bus until START
    PH_ADDR = 2'd1,  // receiving address byte
    PH_RX   = 2'd2,  // controller writes, engine receives
    PH_TX   = 2'd3   // controller reads, engine transmits
  } phase_t;

  // Host register selects
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_OWN  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  // Status bit positions
  localparam int ST_IRQ  = 0;
  localparam int ST_HIT  = 1;
  localparam int ST_TX   = 2;
  localparam int ST_NACK = 3;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] scl_ff, sda_ff;
  logic         scl_d, sda_d;

  // Synchronizer chain plus one delay stage for edge detection; idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[N-2:0], scl_i};
      sda_ff <= {sda_ff[N-2:0], sda_i};
      scl_d  <= scl_ff[N-1];
      sda_d  <= sda_ff[N-1];
    end
  end

  assign scl_s     = scl_ff[N-1];
  assign sda_s     = sda_ff[N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              addr_hit,
  output logic              tx_mode,
  output logic              nack_seen,
  output logic [DATA_W-1:0] data_q
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lead_q;
  logic [DATA_W-1:0] shift_q;
  logic              hold_q, sda_q, irq_q, hit_q, tx_q, nack_q;
  logic              release_hold;

  // The hold ends only through the data access that matches the direction
  assign release_hold = hold_q & (tx_q ? data_wr : data_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      shift_q <= '0;
      data_q  <= '0;
      hold_q  <= 1'b0;
      sda_q   <= 1'b0;
      irq_q   <= 1'b0;
      hit_q   <= 1'b0;
      tx_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      if (data_wr) data_q <= wdata;
      if (release_hold) begin
        hold_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (start_det) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        lead_q  <= 1'b1;
        hold_q  <= 1'b0;
        irq_q   <= 1'b0;
        hit_q   <= 1'b0;
        sda_q   <= 1'b0;
        tx_q    <= 1'b0;
        nack_q  <= 1'b0;
      end else if (stop_det) begin
        phase_q <= PH_IDLE;
        lead_q  <= 1'b0;
        hold_q  <= 1'b0;
        irq_q   <= 1'b0;
        hit_q   <= 1'b0;
        sda_q   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt_q != ACK_BIT) begin
            if (phase_q != PH_TX) shift_q <= {shift_q[DATA_W-2:0], sda_s};
          end else if (phase_q == PH_TX) begin
            nack_q <= sda_s;
          end
        end
        if (scl_fall) begin
          if (lead_q) begin
            lead_q <= 1'b0;  // falling edge that completes the START
          end else if (cnt_q == LAST_BIT) begin
            cnt_q <= ACK_BIT;
            case (phase_q)
              PH_ADDR: begin
                if (shift_q[DATA_W-1:1] == own_addr) begin
                  hit_q  <= 1'b1;
                  irq_q  <= 1'b1;
                  hold_q <= 1'b1;
                  sda_q  <= 1'b1;
                  tx_q   <= shift_q[0];
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_RX: begin
                data_q <= shift_q;
                irq_q  <= 1'b1;
                hold_q <= 1'b1;
                sda_q  <= 1'b1;
              end
              PH_TX: begin
                irq_q  <= 1'b1;
                hold_q <= 1'b1;
                sda_q  <= 1'b0;
              end
              default: ;
            endcase
          end else if (cnt_q == ACK_BIT) begin
            cnt_q <= '0;
            if (phase_q == PH_TX) begin
              if (nack_q) begin
                phase_q <= PH_IDLE;
                sda_q   <= 1'b0;
              end else begin
                shift_q <= data_q;
                sda_q   <= ~data_q[DATA_W-1];
              end
            end else begin
              phase_q <= tx_q ? PH_TX : PH_RX;
              if (tx_q) begin
                shift_q <= data_q;
                sda_q   <= ~data_q[DATA_W-1];
              end else begin
                sda_q <= 1'b0;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (phase_q == PH_TX) begin
              shift_q <= {shift_q[DATA_W-2:0], 1'b0};
              sda_q   <= ~shift_q[DATA_W-2];
            end
          end
        end
      end
    end
  end

  assign scl_oe    = hold_q;
  assign sda_oe    = sda_q;
  assign irq       = irq_q;
  assign addr_hit  = hit_q;
  assign tx_mode   = tx_q;
  assign nack_seen = nack_q;

  // R7
  stall_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(scl_fall));

  // R8
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && tx_q && data_wr && !start_det && !stop_det) |=> !hold_q);

  // R8
  rx_keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !tx_q && !data_rd && !start_det && !stop_det) |=> hold_q);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (!sda_q && !hold_q));

  // R12
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_q != $past(sda_q)) && !$past(start_det || stop_det)) |-> !$past(scl_s));

endmodule

// File: rtl/i2ct_hostif.sv
module i2ct_hostif
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              irq,
  input  logic              addr_hit,
  input  logic              tx_mode,
  input  logic              nack_seen,
  input  logic [DATA_W-1:0] data_q,
  output logic [DATA_W-2:0] own_addr,
  output logic              data_wr,
  output logic              data_rd,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int ADDR_W = DATA_W - 1;

  logic [ADDR_W-1:0] own_q;
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= '0;
    else if (reg_wr && reg_sel == SEL_OWN) own_q <= reg_wdata[ADDR_W-1:0];
  end

  always_comb begin
    status          = '0;
    status[ST_IRQ]  = irq;
    status[ST_HIT]  = addr_hit;
    status[ST_TX]   = tx_mode;
    status[ST_NACK] = nack_seen;
  end

  always_comb begin
    case (reg_sel)
      SEL_DATA: reg_rdata = data_q;
      SEL_OWN:  reg_rdata = {1'b0, own_q};
      SEL_STAT: reg_rdata = status;
      default:  reg_rdata = '0;
    endcase
  end

  assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
  assign data_rd  = reg_rd && (reg_sel == SEL_DATA);
  assign own_addr = own_q;

  // R11
  own_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == SEL_OWN) |=> $stable(own_q));

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2ct_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              addr_hit
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic data_wr, data_rd, tx_mode, nack_seen;
  logic [DATA_W-2:0] own_addr;
  logic [DATA_W-1:0] data_q;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2ct_engine #(.DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .own_addr  (own_addr),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .wdata     (reg_wdata),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq       (irq),
    .addr_hit  (addr_hit),
    .tx_mode   (tx_mode),
    .nack_seen (nack_seen),
    .data_q    (data_q)
  );

  i2ct_hostif #(.DATA_W(DATA_W)) u_hostif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .addr_hit  (addr_hit),
    .tx_mode   (tx_mode),
    .nack_seen (nack_seen),
    .data_q    (data_q),
    .own_addr  (own_addr),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/i2c_target_stretch_tb_top.sv
module i2c_target_stretch_tb_top;

  localparam int Q = 4;
  localparam logic [1:0] S_DATA = 2'd0, S_OWN = 2'd1, S_STAT = 2'd2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq, addr_hit;
  logic       scl_line, sda_line;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_target_stretch dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .addr_hit(addr_hit)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_b [8];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic m_start();
    while (!scl_line) @(negedge clk);
    idle(Q); m_sda_low = 1'b1; idle(Q); m_scl_low = 1'b1; idle(Q);
  endtask

  task automatic m_rstart();
    m_sda_low = 1'b0; idle(Q); m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    idle(Q); m_sda_low = 1'b1; idle(Q); m_scl_low = 1'b1; idle(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; idle(Q); m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    idle(Q); m_sda_low = 1'b0; idle(Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = ~b; idle(Q); m_scl_low = 1'b0; idle(1);
    while (!scl_line) @(negedge clk);
    idle(Q); r = sda_line; m_scl_low = 1'b1; idle(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(~give_ack, r);
  endtask

  // Host side of a controller-write transfer: address event plus n byte events
  task automatic h_rx(input int n);
    logic [7:0] d;
    for (int k = 0; k <= n; k++) begin
      while (!irq) @(negedge clk);
      idle(12);
      chk("R7 scl held", int'(scl_line), 0);
      if (k == 0) begin
        chk("R2 addr_hit", int'(addr_hit), 1);
        host_rd(S_STAT, d);
        chk("R4 rx mode bit", int'(d[2]), 0);
        host_wr(S_DATA, 8'h99);
        idle(8);
        chk("R8 hold kept after status read and rx data write", int'(scl_line), 0);
      end
      host_rd(S_DATA, d);
      if (k > 0) chk("R5 received byte", int'(d), int'(exp_b[k-1]));
      idle(2);
      chk("R8 rx release by read", int'(irq), 0);
    end
  endtask

  // Host side of a controller-read transfer
  task automatic h_tx(input int n);
    logic [7:0] d;
    for (int k = 0; k <= n; k++) begin
      while (!irq) @(negedge clk);
      idle(12);
      chk("R7 scl held", int'(scl_line), 0);
      if (k == 0) begin
        host_rd(S_STAT, d);
        chk("R4 tx mode bit", int'(d[2]), 1);
      end
      host_rd(S_DATA, d);
      idle(8);
      chk("R8 hold kept after tx data read", int'(scl_line), 0);
      host_wr(S_DATA, (k < n) ? exp_b[k] : 8'h00);
      idle(2);
      chk("R8 tx release by write", int'(irq), 0);
    end
  endtask

  task automatic wr_txn(input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] d;
    fork
      begin
        m_start();
        m_wbyte({a, 1'b0}, ack);
        chk("R2 address ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
          m_wbyte(exp_b[k], ack);
          chk("R5 data ack", int'(ack), 1);
        end
        m_stop();
      end
      h_rx(n);
    join
    idle(8);
    host_rd(S_STAT, d);
    chk("R10 status clear after stop", int'(d[1:0]), 0);
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] d;
    fork
      begin
        m_start();
        m_wbyte({a, 1'b1}, ack);
        chk("R2 address ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
          m_rbyte(d, k < n - 1);
          chk("R6 sent byte", int'(d), int'(exp_b[k]));
        end
        m_rbyte(d, 1'b0);
        chk("R9 released after nack", int'(d), 8'hFF);
        chk("R9 no irq after nack", int'(irq), 0);
        m_stop();
      end
      h_tx(n);
    join
    idle(8);
  endtask

  initial begin
    logic [7:0] d;
    logic ack;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 addr_hit", int'(addr_hit), 0);
    host_rd(S_DATA, d); chk("R1 data reg", int'(d), 0);
    host_rd(S_OWN, d);  chk("R1 own reg", int'(d), 0);

    // Matching address at several own-address values
    for (int s = 0; s < 4; s++) begin
      logic [6:0] own;
      own = 7'((s * 45 + 0) % 128) ^ ((s == 3) ? 7'h7F : 7'h00);
      host_wr(S_OWN, {1'b0, own});
      for (int k = 0; k < 4; k++) exp_b[k] = 8'((k * 73 + s * 29 + 1) ^ (k == 2 ? 8'hFF : 8'h00));
      wr_txn(own, 4);
      for (int k = 0; k < 4; k++) exp_b[k] = 8'(8'h80 >> k) | 8'(k * 3);
      rd_txn(own, 4);
      host_rd(S_OWN, d);
      chk("R11 own address unchanged by traffic", int'(d), int'(own));
    end

    // Repeated START between a write and a read
    host_wr(S_OWN, 8'h5A);
    exp_b[0] = 8'hC3;
    fork
      begin
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        m_wbyte(exp_b[0], ack);
        m_rstart();
        chk("R10 addr_hit cleared by repeated start", int'(addr_hit), 0);
        m_wbyte({7'h5A, 1'b1}, ack);
        chk("R10 address ack after repeated start", int'(ack), 1);
        m_rbyte(d, 1'b0);
        chk("R6 byte after repeated start", int'(d), 8'hC3);
        m_stop();
      end
      begin
        h_rx(1);
        h_tx(1);
      end
    join
    idle(8);

    // Every non-matching address is ignored
    for (int a = 0; a < 128; a++) begin
      if (a != 8'h5A) begin
        m_start();
        m_wbyte({7'(a), 1'(a % 2)}, ack);
        chk("R3 no address ack", int'(ack), 0);
        chk("R3 no irq", int'(irq), 0);
        m_wbyte(8'h00, ack);
        chk("R3 later byte ignored", int'(ack), 0);
        m_stop();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule